// File: doc/BRIEF.md
# Multi-Streamer Output Combiner

This block merges the data words produced by several independent pattern streamers into a single output bus. A mode input chooses how the words are merged. It can pass one streamer through unchanged. It can form a bitwise AND, OR, XOR or XNOR over the streamers that are enabled, or take a bitwise majority vote over them. It can pack a narrow field from each streamer side by side into one word. It can also add the enabled words, or subtract one fixed streamer word from another.

The merged word then passes through a per-bit mask, which forces bits to zero, and then a per-bit inversion. The result is registered, so each output value reflects the inputs sampled at the previous rising clock edge. Every control input is sampled on the same edge as the data. A change of mode therefore applies cleanly from one word to the next, and no mixture of two modes ever reaches the output.

Top module: `stream_combiner`

## Requirements
- R1: While `rst_n` is low, `data_o` is zero.
- R2: `data_o` after a rising edge equals the function of the inputs sampled at that edge, so consecutive words may use different modes with no carry-over between them.
- R3: Mode code 0 (select) outputs the word of streamer `sel_i`, whatever `en_i` holds.
- R4: Mode codes 1, 2 and 3 give the bitwise AND, OR and XOR of the enabled streamers. With no streamer enabled, AND gives all ones and OR and XOR give zero.
- R5: Mode code 4 gives the bitwise complement of the mode 3 result for the same inputs.
- R6: Mode code 5 sets each output bit to 1 only when the number of enabled streamers holding 1 at that position is more than half of the number enabled. A tie, or no streamer enabled, gives 0.
- R7: Mode code 6 fills output bits [k*W/N +: W/N] from the low W/N bits of streamer k, for each k from 0 to N-1. Any leftover high bits are zero. Enables are ignored.
- R8: Mode code 7 gives the sum, modulo 2^W, of the enabled streamer words. The sum is zero when none is enabled.
- R9: Mode code 8 gives streamer 0 minus streamer 1, modulo 2^W, whatever `en_i` holds.
- R10: The merged word is masked first and inverted second: each bit of `data_o` is (merged AND `mask_i`) XOR `inv_i`.
- R11: Mode codes 9 to 15 give a merged word of zero, so `data_o` equals the registered `inv_i`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 4 | Merge mode code (0 to 8 used) |
| sel_i | input | $clog2(N) | Streamer index for select mode |
| en_i | input | N | Per-streamer enable for the logic, majority and sum modes |
| words_i | input | N*W | Streamer words packed together; streamer k sits in bits [k*W +: W] |
| mask_i | input | W | Per-bit mask; a 0 forces the merged bit to 0 |
| inv_i | input | W | Per-bit inversion applied after the mask |
| data_o | output | W | Registered combined word |

## Verification
Each merge mode is driven with several enable patterns: all streamers, a strict subset, a single streamer and none. This separates the enable-aware modes from select, concatenation and difference, which must ignore `en_i`. The majority mode is given two-against-two ties and three-of-four votes, to separate a strict majority from a half-or-more majority. Sum and difference use operands that carry out of the top bit and borrow past zero, which exposes any lost wrap or swapped operands. Back-to-back mode changes and a long run of random words with random masks and inversions show that each output word depends only on its own sampled inputs.

// File: rtl/stream_combiner_pkg.sv
`timescale 1ns/1ps
package stream_combiner_pkg;

  localparam int MODE_W = 4;

  typedef enum logic [MODE_W-1:0] {
    CMB_SEL  = 4'd0,
    CMB_AND  = 4'd1,
    CMB_OR   = 4'd2,
    CMB_XOR  = 4'd3,
    CMB_XNOR = 4'd4,
    CMB_MAJ  = 4'd5,
    CMB_CAT  = 4'd6,
    CMB_SUM  = 4'd7,
    CMB_DIFF = 4'd8
  } cmb_mode_e;

  // True when the number of ones exceeds half of the number voting (R6)
  function automatic logic strict_majority(input int unsigned ones, input int unsigned voters);
    return (2 * ones) > voters;
  endfunction

  // True for the mode codes that have a defined merge (R11)
  function automatic logic mode_is_legal(input logic [MODE_W-1:0] m);
    return m <= CMB_DIFF;
  endfunction

endpackage

// File: rtl/cmb_bitwise.sv
`timescale 1ns/1ps
module cmb_bitwise #(
  parameter int N = 4,
  parameter int W = 32
) (
  input  logic [N*W-1:0] words_i,
  input  logic [N-1:0]   en_i,
  output logic [W-1:0]   and_o,
  output logic [W-1:0]   or_o,
  output logic [W-1:0]   xor_o,
  output logic [W-1:0]   maj_o
);
  import stream_combiner_pkg::*;

  always_comb begin
    and_o = '1;
    or_o  = '0;
    xor_o = '0;
    for (int k = 0; k < N; k++) begin
      if (en_i[k]) begin
        and_o = and_o & words_i[k*W +: W];
        or_o  = or_o  | words_i[k*W +: W];
        xor_o = xor_o ^ words_i[k*W +: W];
      end
    end
  end

  // Bitwise vote over enabled streamers
  always_comb begin
    int unsigned voters;
    voters = 0;
    for (int k = 0; k < N; k++) begin
      if (en_i[k]) voters = voters + 1;
    end
    for (int b = 0; b < W; b++) begin
      int unsigned ones;
      ones = 0;
      for (int k = 0; k < N; k++) begin
        if (en_i[k] && words_i[k*W + b]) ones = ones + 1;
      end
      maj_o[b] = strict_majority(ones, voters);
    end
  end

endmodule

// File: rtl/cmb_arith.sv
`timescale 1ns/1ps
module cmb_arith #(
  parameter int N = 4,
  parameter int W = 32
) (
  input  logic [N*W-1:0] words_i,
  input  logic [N-1:0]   en_i,
  output logic [W-1:0]   sum_o,
  output logic [W-1:0]   diff_o
);

  // Sum of enabled words, wrapping at W bits
  always_comb begin
    sum_o = '0;
    for (int k = 0; k < N; k++) begin
      if (en_i[k]) sum_o = sum_o + words_i[k*W +: W];
    end
  end

  generate
    if (N >= 2) begin : g_diff
      assign diff_o = words_i[0 +: W] - words_i[W +: W];
    end else begin : g_diff_single
      assign diff_o = words_i[0 +: W];
    end
  endgenerate

endmodule

// File: rtl/cmb_concat.sv
`timescale 1ns/1ps
module cmb_concat #(
  parameter int N = 4,
  parameter int W = 32
) (
  input  logic [N*W-1:0] words_i,
  output logic [W-1:0]   cat_o
);
  localparam int SLICE = W / N;
  localparam int USED  = SLICE * N;

  generate
    for (genvar k = 0; k < N; k++) begin : g_slice
      assign cat_o[k*SLICE +: SLICE] = words_i[k*W +: SLICE];
    end
    if (USED < W) begin : g_pad
      assign cat_o[W-1:USED] = '0;
    end
  endgenerate

endmodule

// File: rtl/stream_combiner.sv
`timescale 1ns/1ps
module stream_combiner #(
  parameter int N = 4,
  parameter int W = 32,
  localparam int SELW = (N > 1) ? $clog2(N) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [3:0]      mode_i,
  input  logic [SELW-1:0] sel_i,
  input  logic [N-1:0]    en_i,
  input  logic [N*W-1:0]  words_i,
  input  logic [W-1:0]    mask_i,
  input  logic [W-1:0]    inv_i,
  output logic [W-1:0]    data_o
);
  import stream_combiner_pkg::*;

  logic [W-1:0] sel_word, and_w, or_w, xor_w, maj_w, cat_w, sum_w, diff_w;
  logic [W-1:0] cmb_word;
  logic [W-1:0] shaped_word;
  logic         mode_legal;

  always_comb begin
    sel_word = '0;
    for (int i = 0; i < N; i++) begin
      if (sel_i == SELW'(i)) sel_word = words_i[i*W +: W];
    end
  end

  cmb_bitwise #(.N(N), .W(W)) u_bitwise (
    .words_i (words_i),
    .en_i    (en_i),
    .and_o   (and_w),
    .or_o    (or_w),
    .xor_o   (xor_w),
    .maj_o   (maj_w)
  );

  cmb_arith #(.N(N), .W(W)) u_arith (
    .words_i (words_i),
    .en_i    (en_i),
    .sum_o   (sum_w),
    .diff_o  (diff_w)
  );

  cmb_concat #(.N(N), .W(W)) u_concat (
    .words_i (words_i),
    .cat_o   (cat_w)
  );

  assign mode_legal = mode_is_legal(mode_i);

  always_comb begin
    unique case (mode_i)
      CMB_SEL:  cmb_word = sel_word;
      CMB_AND:  cmb_word = and_w;
      CMB_OR:   cmb_word = or_w;
      CMB_XOR:  cmb_word = xor_w;
      CMB_XNOR: cmb_word = ~xor_w;
      CMB_MAJ:  cmb_word = maj_w;
      CMB_CAT:  cmb_word = cat_w;
      CMB_SUM:  cmb_word = sum_w;
      CMB_DIFF: cmb_word = diff_w;
      default:  cmb_word = '0;
    endcase
  end

  // Mask first, invert second
  assign shaped_word = (cmb_word & mask_i) ^ inv_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) data_o <= '0;
    else        data_o <= shaped_word;
  end

endmodule

// File: rtl/stream_combiner_chk.sv
`timescale 1ns/1ps
module stream_combiner_chk #(
  parameter int N = 4,
  parameter int W = 32,
  localparam int SELW = (N > 1) ? $clog2(N) : 1
) (
  input logic            clk,
  input logic            rst_n,
  input logic [3:0]      mode_i,
  input logic [SELW-1:0] sel_i,
  input logic [N*W-1:0]  words_i,
  input logic [W-1:0]    mask_i,
  input logic [W-1:0]    inv_i,
  input logic [W-1:0]    data_o,
  input logic            mode_legal
);

  logic [W-1:0] pick_word;
  logic [W-1:0] sub_word;

  always_comb begin
    pick_word = '0;
    for (int i = 0; i < N; i++) begin
      if (int'(sel_i) == i) pick_word = words_i[i*W +: W];
    end
  end

  generate
    if (N >= 2) begin : g_sub
      assign sub_word = words_i[0 +: W] + (~words_i[W +: W]) + W'(1);
    end else begin : g_sub1
      assign sub_word = words_i[0 +: W];
    end
  endgenerate

  // R1: output cleared while reset is held
  a_r1_reset_clear: assert property (@(posedge clk)
    !rst_n |-> data_o == '0);

  // R10: bits removed by the mask show only the inversion pattern
  a_r10_mask_then_invert: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ((data_o & ~$past(mask_i)) == ($past(inv_i) & ~$past(mask_i))));

  // R3: select mode passes the chosen streamer
  a_r3_select: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(mode_i) == 4'd0)
      |-> data_o == (($past(pick_word) & $past(mask_i)) ^ $past(inv_i)));

  // R9: difference wraps modulo 2^W
  a_r9_difference: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(mode_i) == 4'd8)
      |-> data_o == (($past(sub_word) & $past(mask_i)) ^ $past(inv_i)));

  // R11: unused mode codes leave only the inversion pattern
  a_r11_unused_mode: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(mode_legal)) |-> data_o == $past(inv_i));

endmodule

bind stream_combiner stream_combiner_chk #(.N(N), .W(W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mode_i     (mode_i),
  .sel_i      (sel_i),
  .words_i    (words_i),
  .mask_i     (mask_i),
  .inv_i      (inv_i),
  .data_o     (data_o),
  .mode_legal (mode_legal)
);

// File: tb/stream_combiner_tb.sv
`timescale 1ns/1ps
module stream_combiner_tb;
  localparam int N = 4;
  localparam int W = 32;
  localparam int SELW = 2;
  localparam int S = W / N;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [3:0]      mode_i = '0;
  logic [SELW-1:0] sel_i = '0;
  logic [N-1:0]    en_i = '0;
  logic [N*W-1:0]  words_i = '0;
  logic [W-1:0]    mask_i = '0;
  logic [W-1:0]    inv_i = '0;
  logic [W-1:0]    data_o;

  typedef struct {
    logic [W-1:0] exp;
    string        tag;
  } item_t;

  item_t sb_q[$];
  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  stream_combiner #(.N(N), .W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .sel_i(sel_i), .en_i(en_i),
    .words_i(words_i), .mask_i(mask_i), .inv_i(inv_i), .data_o(data_o)
  );

  function automatic logic [W-1:0] model(input logic [3:0] m, input int s,
      input logic [N-1:0] e, input logic [N*W-1:0] ws,
      input logic [W-1:0] mk, input logic [W-1:0] iv);
    logic [W-1:0] w [N];
    logic [W-1:0] r;
    int nen;
    for (int k = 0; k < N; k++) w[k] = ws[k*W +: W];
    nen = 0;
    for (int k = 0; k < N; k++) nen += int'(e[k]);
    r = '0;
    case (m)
      4'd0: r = w[s];
      4'd1: begin r = '1; for (int k = 0; k < N; k++) if (e[k]) r = r & w[k]; end
      4'd2: for (int k = 0; k < N; k++) if (e[k]) r = r | w[k];
      4'd3, 4'd4: begin
        for (int b = 0; b < W; b++) begin
          int c = 0;
          for (int k = 0; k < N; k++) if (e[k] && w[k][b]) c++;
          r[b] = (c % 2) == 1;
        end
        if (m == 4'd4) r = ~r;
      end
      4'd5: for (int b = 0; b < W; b++) begin
        int c = 0;
        for (int k = 0; k < N; k++) if (e[k] && w[k][b]) c++;
        r[b] = (c > nen / 2) && !(nen % 2 == 0 && c == nen / 2);
      end
      4'd6: for (int k = 0; k < N; k++) r[k*S +: S] = w[k][S-1:0];
      4'd7: begin
        longint unsigned acc = 0;
        for (int k = 0; k < N; k++) if (e[k]) acc += longint'(w[k]);
        r = acc[W-1:0];
      end
      4'd8: r = w[0] + ~w[1] + 1;
      default: r = '0;
    endcase
    return (r & mk) ^ iv;
  endfunction

  task automatic drive(input logic [3:0] m, input int s, input logic [N-1:0] e,
      input logic [W-1:0] w0, input logic [W-1:0] w1, input logic [W-1:0] w2,
      input logic [W-1:0] w3, input logic [W-1:0] mk, input logic [W-1:0] iv,
      input string tag);
    item_t it;
    @(negedge clk);
    mode_i = m; sel_i = SELW'(s); en_i = e;
    words_i = {w3, w2, w1, w0}; mask_i = mk; inv_i = iv;
    it.exp = model(m, s, e, {w3, w2, w1, w0}, mk, iv);
    it.tag = tag;
    sb_q.push_back(it);
  endtask

  // Monitor: each word appears one edge after its inputs were driven
  always @(posedge clk) begin
    #1;
    if (rst_n && sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      checks++;
      if (data_o !== it.exp) begin
        errors++;
        $display("FAIL %s: got %h expected %h", it.tag, data_o, it.exp);
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: got hung expected done");
    finish_run();
  end

  localparam logic [W-1:0] A = 32'hF0F0_1234;
  localparam logic [W-1:0] B = 32'hFF00_5678;
  localparam logic [W-1:0] C = 32'h0FF0_9ABC;
  localparam logic [W-1:0] D = 32'h3C3C_DEF0;
  localparam logic [W-1:0] ONES = '1;

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    checks++;
    if (data_o !== '0) begin
      errors++;
      $display("FAIL R1 reset: got %h expected %h", data_o, '0);
    end
    @(negedge clk);
    rst_n = 1'b1;

    // R3 select each streamer, enables cleared
    for (int s = 0; s < N; s++) drive(4'd0, s, 4'b0000, A, B, C, D, ONES, '0, "R3 select");
    // R4 logic over all, subset, none
    drive(4'd1, 0, 4'b1111, A, B, C, D, ONES, '0, "R4 and all");
    drive(4'd1, 0, 4'b0101, A, B, C, D, ONES, '0, "R4 and subset");
    drive(4'd1, 0, 4'b0000, A, B, C, D, ONES, '0, "R4 and none");
    drive(4'd2, 0, 4'b0110, A, B, C, D, ONES, '0, "R4 or subset");
    drive(4'd2, 0, 4'b0000, A, B, C, D, ONES, '0, "R4 or none");
    drive(4'd3, 0, 4'b1111, A, B, C, D, ONES, '0, "R4 xor all");
    drive(4'd3, 0, 4'b0000, A, B, C, D, ONES, '0, "R4 xor none");
    // R5 xnor
    drive(4'd4, 0, 4'b1011, A, B, C, D, ONES, '0, "R5 xnor subset");
    drive(4'd4, 0, 4'b0000, A, B, C, D, ONES, '0, "R5 xnor none");
    // R6 majority: ties of two against two, three of four, three enabled
    drive(4'd5, 0, 4'b1111, 32'h0000_00FF, 32'h0000_0F0F, 32'h0000_FF00, 32'h0000_00F0, ONES, '0, "R6 maj tie");
    drive(4'd5, 0, 4'b1111, 32'h0000_FFFF, 32'h00FF_00FF, 32'h0F0F_0F0F, 32'h0000_0000, ONES, '0, "R6 maj four");
    drive(4'd5, 0, 4'b0111, 32'h0000_FFFF, 32'h00FF_00FF, 32'h0F0F_0F0F, ONES, ONES, '0, "R6 maj three");
    drive(4'd5, 0, 4'b0100, A, B, C, D, ONES, '0, "R6 maj single");
    drive(4'd5, 0, 4'b0000, A, B, C, D, ONES, '0, "R6 maj none");
    // R7 concatenation, enables ignored
    drive(4'd6, 0, 4'b0000, A, B, C, D, ONES, '0, "R7 concat");
    // R8 sum with carry out of the top bit
    drive(4'd7, 0, 4'b1111, ONES, 32'h0000_0001, 32'h8000_0000, 32'h8000_0000, ONES, '0, "R8 sum wrap");
    drive(4'd7, 0, 4'b1010, A, B, C, D, ONES, '0, "R8 sum subset");
    drive(4'd7, 0, 4'b0000, A, B, C, D, ONES, '0, "R8 sum none");
    // R9 difference with borrow, enables ignored
    drive(4'd8, 0, 4'b0000, 32'h0, 32'h1, C, D, ONES, '0, "R9 diff borrow");
    drive(4'd8, 0, 4'b1100, B, A, C, D, ONES, '0, "R9 diff order");
    // R10 mask then invert
    drive(4'd0, 1, 4'b0000, A, B, C, D, 32'h0000_FFFF, 32'h00FF_00FF, "R10 mask invert");
    drive(4'd7, 0, 4'b1111, A, B, C, D, 32'hAAAA_5555, ONES, "R10 mask invert sum");
    // R11 unused codes
    drive(4'd9, 0, 4'b1111, A, B, C, D, ONES, 32'h1234_5678, "R11 unused 9");
    drive(4'd15, 0, 4'b1111, A, B, C, D, ONES, '0, "R11 unused 15");
    // R2 back-to-back mode changes and random words
    for (int i = 0; i < 400; i++) begin
      drive(4'($urandom % 16), int'($urandom % N), 4'($urandom), $urandom, $urandom,
            $urandom, $urandom, $urandom, ($urandom % 3 == 0) ? $urandom : 32'h0, "R2 random stream");
    end
    @(negedge clk);
    @(negedge clk);
    finish_run();
  end

endmodule